// File: doc/BRIEF.md
# Edge-Triggered Interrupt Unit with Timestamp

This block turns a small set of asynchronous external interrupt pins into clean, single-cycle request pulses in the core clock domain. Every pin first passes through a two-flop synchronizer. An edge detector then compares the two most recent synchronized samples. Each channel has its own enable and its own polarity select, so it fires on a rising or a falling transition only when it is enabled.

The highest-numbered pin does two jobs. It feeds the last maskable channel, and it also feeds a separate non-maskable request. That request has its own enable and its own polarity, which are independent of the maskable channel on the same pin.

Each maskable channel owns a free-running up counter. The counter advances on every clock and returns to zero on that channel's qualified edge. Reading it therefore gives the number of cycles since the last accepted event. The enable, polarity and counter values are plain control and status pins. There is no valid/ready stream at the block's edge, because no data flows through it.

Top module: `ext_irq_stamp`

## Requirements
- R1: A change on a pin is seen through a two-flop synchronizer. When a pin changes before clock edge k, the matching request is high from edge k+1 until edge k+2.
- R2: When `ch_rise[i]`=1, channel i requests only on a 0-to-1 transition of `pin_in[i]`.
- R3: When `ch_rise[i]`=0, channel i requests only on a 1-to-0 transition of `pin_in[i]`.
- R4: When `ch_en[i]`=0, `irq_pulse[i]` stays low whatever the pin does.
- R5: Each qualified edge gives exactly one request pulse, one clock cycle wide.
- R6: Each channel counter increments by one on every clock, whether or not its channel is enabled.
- R7: A counter wraps from all ones (0xFFFF at the default width) to zero.
- R8: A qualified edge clears its channel counter, and the clear wins over the increment. The counter reads 0 in the cycle after the pulse and 1 in the cycle after that. Other channels' counters are not affected.
- R9: An edge on a disabled channel does not clear that channel's counter.
- R10: The non-maskable request `nmi_pulse` derives from pin `N_CH-1`. It follows `nmi_en` (1 = enabled) and `nmi_rise` (1 = rising, 0 = falling), independently of `ch_en[N_CH-1]` and `ch_rise[N_CH-1]`.
- R11: While `rst_n` is low, all request outputs are low and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | N_CH | Asynchronous interrupt pins |
| ch_en | input | N_CH | Per-channel enable, 1 = enabled |
| ch_rise | input | N_CH | Per-channel polarity, 1 = rising, 0 = falling |
| nmi_en | input | 1 | Non-maskable request enable |
| nmi_rise | input | 1 | Non-maskable polarity, 1 = rising, 0 = falling |
| irq_pulse | output | N_CH | Per-channel request pulse |
| nmi_pulse | output | 1 | Non-maskable request pulse |
| stamp_flat | output | N_CH*CNT_W | Counters; channel i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench builds the block with its default parameters: three channels and 16-bit counters. At that width a full counter wrap takes 65536 cycles, which keeps the all-ones to zero rollover within the run. Three channels put the shared pin, with its independent non-maskable path, next to two plain channels. This allows checking that a clear on one channel leaves the other counters untouched.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef struct packed {
    logic cur;
    logic prev;
  } samp_pair_t;

  function automatic logic edge_match(samp_pair_t s, logic rise);
    logic up;
    logic down;
    up   = s.cur & ~s.prev;
    down = ~s.cur & s.prev;
    return rise ? up : down;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pin,
  output ext_irq_pkg::samp_pair_t samp
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], pin};
  end

  assign samp.cur  = chain[LAST-1];
  assign samp.prev = chain[LAST];
endmodule

// File: rtl/irq_edge_qual.sv
module irq_edge_qual (
  input  ext_irq_pkg::samp_pair_t samp,
  input  logic                    en,
  input  logic                    rise,
  output logic                    hit
);
  always_comb hit = en & ext_irq_pkg::edge_match(samp, rise);
endmodule

// File: rtl/irq_stamp_ctr.sv
module irq_stamp_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + ONE;
  end
endmodule

// File: rtl/ext_irq_stamp.sv
module ext_irq_stamp #(
  parameter int N_CH        = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       pin_in,
  input  logic [N_CH-1:0]       ch_en,
  input  logic [N_CH-1:0]       ch_rise,
  input  logic                  nmi_en,
  input  logic                  nmi_rise,
  output logic [N_CH-1:0]       irq_pulse,
  output logic                  nmi_pulse,
  output logic [N_CH*CNT_W-1:0] stamp_flat
);
  localparam int NMI_CH = N_CH - 1;

  ext_irq_pkg::samp_pair_t samp [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_in[i]),
      .samp (samp[i])
    );

    irq_edge_qual u_qual (
      .samp(samp[i]),
      .en  (ch_en[i]),
      .rise(ch_rise[i]),
      .hit (irq_pulse[i])
    );

    irq_stamp_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (irq_pulse[i]),
      .cnt  (stamp_flat[i*CNT_W +: CNT_W])
    );
  end

  irq_edge_qual u_nmi_qual (
    .samp(samp[NMI_CH]),
    .en  (nmi_en),
    .rise(nmi_rise),
    .hit (nmi_pulse)
  );
endmodule

// File: rtl/ext_irq_stamp_chk.sv
module ext_irq_stamp_chk #(
  parameter int N_CH  = 3,
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CH-1:0]       ch_en,
  input logic                  nmi_en,
  input logic [N_CH-1:0]       irq_pulse,
  input logic                  nmi_pulse,
  input logic [N_CH*CNT_W-1:0] stamp_flat
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> !irq_pulse[i]);

    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[i] |=> !irq_pulse[i]);

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[i] |=> (stamp_flat[i*CNT_W +: CNT_W] == '0));

    assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pulse[i] |=> (stamp_flat[i*CNT_W +: CNT_W] ==
                         $past(stamp_flat[i*CNT_W +: CNT_W]) + ONE));
  end

  assert_nmi_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_en |-> !nmi_pulse);

  assert_nmi_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !nmi_pulse);
endmodule

bind ext_irq_stamp ext_irq_stamp_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_en     (ch_en),
  .nmi_en    (nmi_en),
  .irq_pulse (irq_pulse),
  .nmi_pulse (nmi_pulse),
  .stamp_flat(stamp_flat)
);

// File: tb/ext_irq_stamp_tb.sv
`timescale 1ns/1ps
module ext_irq_stamp_tb;
  localparam int N_CH  = 3;
  localparam int CNT_W = 16;
  localparam int NVEC  = 10;

  // entry: [9:8] ch, [7] level, [6] en, [5] rise, [4] nmi_en, [3] nmi_rise,
  //        [2] expected irq pulses, [1] expected nmi pulses, [0] spare
  localparam logic [9:0] VEC [NVEC] = '{
    10'b00_1_1_1_0_0_1_0_0,  // R2 rising accepted
    10'b00_0_1_1_0_0_0_0_0,  // R2 falling ignored
    10'b00_1_1_0_0_0_0_0_0,  // R3 rising ignored
    10'b00_0_1_0_0_0_1_0_0,  // R3 falling accepted
    10'b01_1_0_1_0_0_0_0_0,  // R4 disabled
    10'b01_0_1_0_0_0_1_0_0,  // R3 ch1 falling
    10'b10_1_1_1_1_1_1_1_0,  // R10 both rising
    10'b10_0_1_1_1_0_0_1_0,  // R10 nmi falling only
    10'b10_1_0_1_1_1_0_1_0,  // R10 nmi with channel disabled
    10'b10_0_1_0_0_0_1_0_0   // R10 nmi disabled
  };

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [N_CH-1:0]       pin_in = '0;
  logic [N_CH-1:0]       ch_en = '0;
  logic [N_CH-1:0]       ch_rise = '0;
  logic                  nmi_en = 1'b0;
  logic                  nmi_rise = 1'b0;
  logic [N_CH-1:0]       irq_pulse;
  logic                  nmi_pulse;
  logic [N_CH*CNT_W-1:0] stamp_flat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int irq_seen [N_CH];
  int nmi_seen = 0;
  logic [9:0] ent;
  logic [CNT_W-1:0] snap;

  always #2 clk = ~clk;

  ext_irq_stamp #(.N_CH(N_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ch_en(ch_en),
    .ch_rise(ch_rise), .nmi_en(nmi_en), .nmi_rise(nmi_rise),
    .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse), .stamp_flat(stamp_flat)
  );

  initial for (int i = 0; i < N_CH; i++) irq_seen[i] = 0;

  always @(negedge clk) begin
    for (int i = 0; i < N_CH; i++) if (irq_pulse[i]) irq_seen[i]++;
    if (nmi_pulse) nmi_seen++;
  end

  function automatic logic [CNT_W-1:0] stamp(int i);
    return stamp_flat[i*CNT_W +: CNT_W];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int base_irq [N_CH];
    int base_nmi;
    int ch;

    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 irq", {29'd0, irq_pulse}, 32'd0);
    check("R11 nmi", {31'd0, nmi_pulse}, 32'd0);
    check("R11 stamps", {16'd0, stamp_flat[47:32] | stamp_flat[31:16] | stamp_flat[15:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 first count", {16'd0, stamp(0)}, 32'd1);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      ent = VEC[v];
      ch = int'(ent[9:8]);
      ch_en = '0;
      ch_en[ch] = ent[6];
      ch_rise = {N_CH{ent[5]}};
      nmi_en = ent[4];
      nmi_rise = ent[3];
      @(negedge clk);
      for (int i = 0; i < N_CH; i++) base_irq[i] = irq_seen[i];
      base_nmi = nmi_seen;
      pin_in[ch] = ent[7];
      repeat (6) @(negedge clk);
      for (int i = 0; i < N_CH; i++)
        check(i == ch ? "R2/R3/R4 vector irq" : "R5 other channel quiet",
              32'(irq_seen[i] - base_irq[i]), (i == ch) ? {31'd0, ent[2]} : 32'd0);
      check("R10 vector nmi", 32'(nmi_seen - base_nmi), {31'd0, ent[1]});
    end

    // R1, R5 and R8: exact timing and clear priority on channel 0
    ch_en = 3'b001; ch_rise = 3'b111; nmi_en = 1'b0;
    repeat (2) @(negedge clk);
    pin_in[0] = 1'b1;
    snap = stamp(1);
    @(negedge clk);
    check("R1 no pulse after one edge", {31'd0, irq_pulse[0]}, 32'd0);
    @(negedge clk);
    check("R1 pulse after two edges", {31'd0, irq_pulse[0]}, 32'd1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, irq_pulse[0]}, 32'd0);
    check("R8 cleared to zero", {16'd0, stamp(0)}, 32'd0);
    check("R8 other channel untouched", {16'd0, stamp(1)}, {16'd0, snap + 16'd3});
    @(negedge clk);
    check("R8 counts from zero", {16'd0, stamp(0)}, 32'd1);

    // R9 and R6: disabled edge on channel 1 leaves its counter running
    ch_en = 3'b000;
    snap = stamp(1);
    pin_in[1] = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 disabled edge no clear", {16'd0, stamp(1)}, {16'd0, snap + 16'd6});

    // R7 wrap on channel 0
    for (int n = 0; n < 70000 && stamp(0) != 16'hFFFF; n++) @(negedge clk);
    check("R7 reached all ones", {16'd0, stamp(0)}, 32'h0000FFFF);
    @(negedge clk);
    check("R7 wrapped to zero", {16'd0, stamp(0)}, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule